// File: doc/BRIEF.md
# Windowed Watchdog Timer with Ordered Service Key

This block watches over running software and asks for a system reset when the software stops proving it is alive. Software proves this by writing two fixed key bytes, first 0x55 and then 0xAA, to one service location; the write reaches the block as a strobe plus a data byte. The completed pair restarts an internal counter. If the counter reaches its configured limit first, the block pulses a reset request. Any other byte written to the location also causes an immediate request.

Three configuration inputs set the behaviour. A 2-bit period select either turns the block off or picks one of three limits. A source select chooses between counting every bus clock cycle or counting only cycles on which an externally generated 1 kHz tick enable is high. A window enable, which works only when counting bus cycles, rejects any service write that comes before the last quarter of the period. The reset request goes to a system reset controller outside this block.

Top module: `wdog_guard`

## Requirements
- R1: After reset `rst_req` is low and the counter is zero; with period select 2'b11 and the tick source (`cfg_fast`=0) the first request follows the 1024th tick.
- R2: Period select 2'b00 turns the block off: no write value and no amount of time produces a request, and the counter stays at zero.
- R3: With `cfg_fast`=0 the counter advances only on cycles where `tick_1k` is high; period selects 01, 10 and 11 give limits of 32, 256 and 1024 ticks.
- R4: With `cfg_fast`=1 the counter advances every cycle; period selects 01, 10 and 11 give limits of 8192, 65536 and 262144 cycles.
- R5: A write of 0x55 followed by a write of 0xAA is a service: the counter restarts from zero in the cycle the 0xAA write is taken.
- R6: While enabled, a write of any byte other than 0x55 or 0xAA produces a request in the cycle after the write.
- R7: A 0xAA write not preceded by 0x55 is not a service and clears the key tracker; a repeated 0x55 keeps the tracker armed, so 0x55, 0x55, 0xAA is a service.
- R8: With `cfg_fast`=1 and `cfg_window`=1, any write (key bytes included) taken while the count is below three quarters of the limit produces a request; a write at exactly three quarters or later is accepted.
- R9: With `cfg_fast`=0, `cfg_window` has no effect on when service writes are accepted.
- R10: `rst_req` is high for one cycle, one cycle after its cause; after a request the counter and key tracker restart.
- R11: Any change on `cfg_period`, `cfg_fast` or `cfg_window` restarts the counter and clears the key tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle enable from the 1 kHz time base |
| wr_en | input | 1 | Write strobe for the service location |
| wr_data | input | 8 | Byte written to the service location |
| cfg_period | input | 2 | Period select; 2'b00 turns the block off |
| cfg_fast | input | 1 | 1 = count bus cycles, 0 = count ticks |
| cfg_window | input | 1 | Enable the closed window (bus-cycle source only) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench aims at the exact count on which a timeout fires, so a limit that is off by one tick or one cycle shows as a pulse one count early or late. The window edge is probed at one count below and exactly at three quarters of the period; a design comparing with the wrong inequality or the wrong fraction either rejects a legal service or lets an early one through. Lone 0xAA and repeated 0x55 writes expose a tracker that services without the right order or loses its armed state, and a configuration toggle partway through a period exposes a counter that keeps its stale count and fires early. Tick-source tests with the window set catch a design that applies the window to the wrong source.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Configuration snapshot; compared as a whole to detect a change.
  typedef struct packed {
    logic [1:0] period;
    logic       fast;
    logic       window;
  } wdog_cfg_t;

  localparam logic [1:0] PERIOD_OFF = 2'b00;

endpackage

// File: rtl/wdog_cfg_decode.sv
module wdog_cfg_decode
  import wdog_pkg::*;
#(
  parameter int CNT_W = 18,
  parameter int S1 = 5,
  parameter int S2 = 8,
  parameter int S3 = 10,
  parameter int F1 = 13,
  parameter int F2 = 16,
  parameter int F3 = 18
) (
  input  wdog_cfg_t        cfg,
  output logic             enabled,
  output logic             windowed,
  output logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] win_start
);

  localparam int SP_W  = CNT_W + 1;
  localparam int SEL_W = $clog2(SP_W);

  logic [SEL_W-1:0] expo;
  logic [SP_W-1:0]  span;

  always_comb begin
    case ({cfg.fast, cfg.period})
      3'b001:  expo = SEL_W'(S1);
      3'b010:  expo = SEL_W'(S2);
      3'b011:  expo = SEL_W'(S3);
      3'b101:  expo = SEL_W'(F1);
      3'b110:  expo = SEL_W'(F2);
      3'b111:  expo = SEL_W'(F3);
      default: expo = '0;
    endcase
    span      = SP_W'(1) << expo;
    // last count value before expiry, and the count at which the window opens
    last_cnt  = CNT_W'(span - SP_W'(1));
    win_start = CNT_W'(span - (span >> 2));
    enabled   = (cfg.period != PERIOD_OFF);
    windowed  = enabled && cfg.fast && cfg.window;
  end

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq #(
  parameter int             DW    = 8,
  parameter logic [DW-1:0]  KEY_A = DW'(8'h55),
  parameter logic [DW-1:0]  KEY_B = DW'(8'hAA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          active,
  input  logic          premature,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          service,
  output logic          violation
);

  logic armed_q;
  logic hit, is_a, is_b;

  always_comb begin
    hit       = wr_en && active;
    is_a      = (wr_data == KEY_A);
    is_b      = (wr_data == KEY_B);
    violation = hit && (premature || !(is_a || is_b));
    service   = hit && !violation && is_b && armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed_q <= 1'b0;
    end else if (hit) begin
      // first key arms (or re-arms); anything else disarms
      armed_q <= !violation && is_a;
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] last_cnt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  assign expire = step && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (expire) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] KEY_A = DW'(8'h55),
  parameter logic [DW-1:0] KEY_B = DW'(8'hAA),
  parameter int            S1    = 5,
  parameter int            S2    = 8,
  parameter int            S3    = 10,
  parameter int            F1    = 13,
  parameter int            F2    = 16,
  parameter int            F3    = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1k,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    cfg_period,
  input  logic          cfg_fast,
  input  logic          cfg_window,
  output logic          rst_req
);

  localparam int CNT_W = F3;

  wdog_cfg_t        cfg_now, cfg_q;
  logic             cfg_change;
  logic             enabled, windowed;
  logic [CNT_W-1:0] last_cnt, win_start, cnt_q;
  logic             step, expire, premature;
  logic             service, violation, timeout;
  logic             cnt_clr, seq_clr;

  assign cfg_now = '{period: cfg_period, fast: cfg_fast, window: cfg_window};

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  assign cfg_change = (cfg_now != cfg_q);

  wdog_cfg_decode #(
    .CNT_W(CNT_W), .S1(S1), .S2(S2), .S3(S3), .F1(F1), .F2(F2), .F3(F3)
  ) u_decode (
    .cfg       (cfg_now),
    .enabled   (enabled),
    .windowed  (windowed),
    .last_cnt  (last_cnt),
    .win_start (win_start)
  );

  assign step      = enabled && (cfg_fast || tick_1k);
  assign premature = windowed && (cnt_q < win_start);

  wdog_seq #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (seq_clr),
    .active    (enabled),
    .premature (premature),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .service   (service),
    .violation (violation)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .step     (step),
    .last_cnt (last_cnt),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  // a completed service or a config change in the same cycle outranks expiry
  assign timeout = expire && !cfg_change && !service;
  assign cnt_clr = cfg_change || !enabled || service || violation;
  assign seq_clr = cfg_change || timeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= violation || timeout;
    end
  end

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] KEY_A = DW'(8'h55),
  parameter logic [DW-1:0] KEY_B = DW'(8'hAA),
  parameter int            CNT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1k,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic [1:0]       cfg_period,
  input logic             cfg_fast,
  input logic             cfg_window,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] last_cnt,
  input logic [CNT_W-1:0] win_start
);

  logic bad_byte;
  assign bad_byte = wr_en && (wr_data != KEY_A) && (wr_data != KEY_B);

  assert_off_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_period == 2'b00) |=> !rst_req);

  assert_off_count_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_period == 2'b00) |=> (cnt_q == '0));

  assert_bad_value_R6: assert property (@(posedge clk) disable iff (rst)
    (bad_byte && cfg_period != 2'b00) |=> rst_req);

  assert_no_tick_no_timeout_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fast && !tick_1k && !bad_byte) |=> !rst_req);

  assert_early_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_fast && cfg_window && cfg_period != 2'b00 && cnt_q < win_start)
    |=> rst_req);

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_period != 2'b00 && $stable(cfg_period) && $stable(cfg_fast))
    |-> (cnt_q <= last_cnt));

endmodule

bind wdog_guard wdog_guard_chk #(
  .DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_1k    (tick_1k),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .cfg_period (cfg_period),
  .cfg_fast   (cfg_fast),
  .cfg_window (cfg_window),
  .rst_req    (rst_req),
  .cnt_q      (cnt_q),
  .last_cnt   (last_cnt),
  .win_start  (win_start)
);

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1k = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] cfg_period = 2'b11;
  logic       cfg_fast = 1'b0;
  logic       cfg_window = 1'b0;
  logic       rst_req;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  seen = 1'b0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_guard i_wdog_guard (
    .clk        (clk),
    .rst        (rst),
    .tick_1k    (tick_1k),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cfg_period (cfg_period),
    .cfg_fast   (cfg_fast),
    .cfg_window (cfg_window),
    .rst_req    (rst_req)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Ends at the negedge where reset is released; the counter is zero there.
  task automatic do_reset(input logic [1:0] per, input logic fast, input logic win);
    @(negedge clk);
    rst = 1'b1; tick_1k = 1'b0; wr_en = 1'b0;
    cfg_period = per; cfg_fast = fast; cfg_window = win;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    seen = 1'b0;
  endtask

  task automatic cyc();
    @(negedge clk);
    seen = seen | rst_req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // Write taken at the next posedge; returns at the negedge after it.
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1k = 1'b1; cyc();
      tick_1k = 1'b0; cyc(); cyc(); cyc();
    end
  endtask

  // One tick that must raise the request, then a cycle where it must be low.
  task automatic last_tick(input string tag);
    tick_1k = 1'b1;
    @(negedge clk);
    tick_1k = 1'b0;
    chk({tag, " pulse on final tick"}, rst_req, 1);
    @(negedge clk);
    chk("R10 pulse one cycle wide", rst_req, 0);
    seen = 1'b0;
  endtask

  task automatic t_reset_default();
    do_reset(2'b11, 1'b0, 1'b0);
    chk("R1 reset request low", rst_req, 0);
    ticks(1023);
    chk("R1 quiet for 1023 ticks", seen, 0);
    last_tick("R1");
  endtask

  task automatic t_slow_periods();
    do_reset(2'b01, 1'b0, 1'b0);
    ticks(31);
    chk("R3 sel01 quiet for 31 ticks", seen, 0);
    last_tick("R3 sel01");
    do_reset(2'b10, 1'b0, 1'b0);
    ticks(255);
    chk("R3 sel10 quiet for 255 ticks", seen, 0);
    last_tick("R3 sel10");
    // no ticks: no count
    do_reset(2'b01, 1'b0, 1'b0);
    idle(400);
    chk("R3 no tick no timeout", seen, 0);
  endtask

  task automatic t_fast_timeout();
    do_reset(2'b01, 1'b1, 1'b0);
    idle(8191);
    chk("R4 quiet for 8191 cycles", seen, 0);
    @(negedge clk);
    chk("R4 pulse at cycle 8192", rst_req, 1);
    @(negedge clk);
    chk("R10 pulse one cycle wide", rst_req, 0);
  endtask

  task automatic t_service_fast();
    do_reset(2'b01, 1'b1, 1'b0);
    idle(5000);
    wr(8'h55);
    wr(8'hAA);
    chk("R5 service no pulse", rst_req, 0);
    seen = 1'b0;
    idle(8191);
    chk("R5 restarted: quiet 8191 cycles", seen, 0);
    @(negedge clk);
    chk("R5 pulse 8192 cycles after service", rst_req, 1);
  endtask

  task automatic t_bad_value();
    do_reset(2'b11, 1'b0, 1'b0);
    wr(8'h00);
    chk("R6 byte 0x00 requests", rst_req, 1);
    @(negedge clk);
    chk("R10 pulse one cycle wide", rst_req, 0);
    wr(8'hA5);
    chk("R6 byte 0xA5 requests", rst_req, 1);
    do_reset(2'b10, 1'b1, 1'b0);
    idle(10);
    wr(8'h5A);
    chk("R6 byte 0x5A requests (bus source)", rst_req, 1);
  endtask

  task automatic t_order();
    do_reset(2'b01, 1'b0, 1'b0);
    ticks(20);
    wr(8'hAA);
    chk("R7 lone 0xAA no pulse", rst_req, 0);
    seen = 1'b0;
    ticks(11);
    chk("R7 lone 0xAA not a service: quiet", seen, 0);
    last_tick("R7 lone 0xAA");
    do_reset(2'b01, 1'b0, 1'b0);
    ticks(20);
    wr(8'h55); wr(8'h55); wr(8'hAA);
    chk("R7 double 0x55 no pulse", rst_req, 0);
    seen = 1'b0;
    ticks(31);
    chk("R7 double 0x55 then 0xAA services", seen, 0);
    last_tick("R7 double 0x55");
  endtask

  task automatic t_window();
    do_reset(2'b01, 1'b1, 1'b1);
    idle(6143);
    wr(8'h55);
    chk("R8 write at 6143 is premature", rst_req, 1);
    do_reset(2'b01, 1'b1, 1'b1);
    idle(6144);
    wr(8'h55);
    chk("R8 0x55 at 6144 accepted", rst_req, 0);
    wr(8'hAA);
    chk("R8 0xAA in window accepted", rst_req, 0);
    wr(8'h55);
    chk("R8 window closed after service", rst_req, 1);
  endtask

  task automatic t_window_slow();
    do_reset(2'b01, 1'b0, 1'b1);
    wr(8'h55);
    chk("R9 early 0x55 ignored window", rst_req, 0);
    wr(8'hAA);
    chk("R9 early 0xAA ignored window", rst_req, 0);
    seen = 1'b0;
    ticks(31);
    chk("R9 quiet 31 ticks", seen, 0);
    last_tick("R9");
  endtask

  task automatic t_disabled();
    do_reset(2'b00, 1'b1, 1'b0);
    wr(8'h13);
    chk("R2 bad byte while off", rst_req, 0);
    wr(8'hAA);
    idle(9000);
    chk("R2 no timeout while off", seen, 0);
    do_reset(2'b00, 1'b0, 1'b1);
    ticks(40);
    wr(8'h00);
    chk("R2 tick source off", seen | rst_req, 0);
  endtask

  task automatic t_cfg_change();
    do_reset(2'b01, 1'b0, 1'b0);
    ticks(20);
    cfg_window = 1'b1;
    cyc();
    chk("R11 config change no pulse", seen, 0);
    ticks(31);
    chk("R11 counter restarted: quiet 31 ticks", seen, 0);
    last_tick("R11");
  endtask

  initial begin
    t_reset_default();
    t_slow_periods();
    t_fast_timeout();
    t_service_fast();
    t_bad_value();
    t_order();
    t_window();
    t_window_slow();
    t_disabled();
    t_cfg_change();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule